// File: doc/BRIEF.md
# Register Vulnerability Interval Tracker

This block runs next to a small register file and measures how long its stored data is exposed to soft errors. A bit only matters between the write that sets it and the last read that uses it. The tracker watches the register file's write port and read ports. For each register it keeps the cycle of the write and the cycle of the most recent read. When a register is overwritten, it adds the span from write to last read, multiplied by the register width, into a running bit-cycle total. The time after the final read, and values that nobody reads, add nothing.

The cycle count comes in from outside, so the tracker follows whatever time base the surrounding model uses. The subtraction wraps modulo the counter width. A one-cycle end-of-run strobe closes the measurement. The tracker then walks every register once, in ascending index order, one register per cycle. It commits each interval that is still open and has been read, and after that it raises a done flag. The total sits in a saturating accumulator. Turning the total into an error rate is left to the consumer.

Top module: `reg_vuln_tracker`

## Requirements
- R1: While reset is low, and on the first sampled cycle after it is released, `total_o` is 0 and `done_o` is 0.
- R2: A write to a live register whose value has been read adds (last read cycle − write cycle) × DATA_W to `total_o`. The difference is taken modulo 2^CYC_W. The new total is visible in the cycle after the overwrite.
- R3: When one written value is read several times, only the latest read ends its interval. Earlier reads do not add anything of their own.
- R4: No write that the tracker acts on and no flush step means no change in `total_o`. A value overwritten without any read adds 0. Reads of a register that has never been written since reset are ignored, so its first overwrite adds 0.
- R5: A read and a write to the same register in the same cycle count the read against the old value. The interval ends at that cycle, and the new value starts unread.
- R6: Both read ports are tracked. A read on either port, or on both ports to different registers in one cycle, extends the interval of each register it names.
- R7: An `end_run_i` pulse in the run state still applies that cycle's accesses. On the following NUM_REGS cycles the tracker commits register 0, 1, … NUM_REGS−1 in turn, each only if it holds a read value. `done_o` rises after the last of these commits, together with the final total, and stays high until reset.
- R8: From the cycle after the end strobe until reset, the write port, the read ports and further strobes have no effect on `total_o`.
- R9: `total_o` saturates at 2^ACC_W − 1 instead of wrapping. Once it is saturated, it stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_i | input | CYC_W | Current cycle number of the observed run |
| wr_en_i | input | 1 | Register file write enable |
| wr_idx_i | input | IDX_W | Register written |
| rd_en_i | input | NUM_RD | One enable per read port |
| rd_idx_i | input | NUM_RD×IDX_W | Read indices, port p in bits [p×IDX_W +: IDX_W] |
| end_run_i | input | 1 | End-of-run strobe, one cycle |
| total_o | output | ACC_W | Accumulated vulnerable bit-cycles |
| done_o | output | 1 | Flush finished; total is final |

## Verification
An overwrite changes `total_o` one cycle later, because the total has a single register stage. The bench drives inputs on the falling edge and compares against its reference on the next falling edge. That reference is behavioural and updated at the same rising edge. After an end strobe at edge e, the commit for register k arrives at edge e+k+1 and `done_o` rises at edge e+NUM_REGS. The bench counts those edges one by one and expects `done_o` low on every sample before the last. Directed sequences check fixed totals worked out by hand. Cycle-number jumps drive the saturation case without long runs.

// File: rtl/vt_pkg.sv
package vt_pkg;

    typedef enum logic [1:0] {
        VT_RUN   = 2'd0,
        VT_FLUSH = 2'd1,
        VT_DONE  = 2'd2
    } vt_mode_e;

endpackage

// File: rtl/vt_slot.sv
// Per-register interval record: write cycle, latest read cycle, flags.
module vt_slot #(
    parameter int CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] cycle_i,
    input  logic             wr_hit_i,
    input  logic             rd_hit_i,
    input  logic             flush_hit_i,
    output logic             commit_o,
    output logic [CYC_W-1:0] span_o
);

    typedef struct packed {
        logic             live;   // written since reset
        logic             seen;   // current value read at least once
        logic [CYC_W-1:0] born;   // cycle of the write
        logic [CYC_W-1:0] last;   // cycle of the latest read
    } slot_t;

    slot_t slot_d, slot_q;
    logic  rd_ok;
    logic [CYC_W-1:0] end_cyc;

    always_comb begin
        slot_d   = slot_q;
        rd_ok    = rd_hit_i & slot_q.live;
        // A read in this cycle belongs to the value held before any write.
        end_cyc  = rd_ok ? cycle_i : slot_q.last;
        span_o   = end_cyc - slot_q.born;
        commit_o = (wr_hit_i | flush_hit_i) & slot_q.live & (slot_q.seen | rd_ok);

        if (rd_ok) begin
            slot_d.seen = 1'b1;
            slot_d.last = cycle_i;
        end
        if (wr_hit_i) begin
            slot_d.live = 1'b1;
            slot_d.seen = 1'b0;
            slot_d.born = cycle_i;
        end
        if (flush_hit_i) begin
            slot_d.seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

endmodule

// File: rtl/vt_sat_add.sv
// Saturating adder: sum clamps to all ones on carry out.
module vt_sat_add #(
    parameter int ACC_W = 64,
    parameter int ADD_W = 38
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ADD_W-1:0] inc_i,
    output logic [ACC_W-1:0] sum_o
);

    localparam int EXT_W = ACC_W + 1;

    logic [EXT_W-1:0] wide;

    always_comb begin
        wide  = {1'b0, acc_i} + EXT_W'(inc_i);
        sum_o = wide[ACC_W] ? {ACC_W{1'b1}} : wide[ACC_W-1:0];
    end

endmodule

// File: rtl/reg_vuln_tracker.sv
module reg_vuln_tracker
    import vt_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int NUM_RD   = 2,
    parameter int CYC_W    = 32,
    parameter int ACC_W    = 64,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CYC_W-1:0]        cycle_i,
    input  logic                    wr_en_i,
    input  logic [IDX_W-1:0]        wr_idx_i,
    input  logic [NUM_RD-1:0]       rd_en_i,
    input  logic [NUM_RD*IDX_W-1:0] rd_idx_i,
    input  logic                    end_run_i,
    output logic [ACC_W-1:0]        total_o,
    output logic                    done_o
);

    localparam int WID_W = $clog2(DATA_W) + 1;
    localparam int ADD_W = CYC_W + WID_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    typedef struct packed {
        vt_mode_e         mode;
        logic [IDX_W-1:0] ptr;
        logic [ACC_W-1:0] total;
    } trk_t;

    trk_t st_d, st_q;

    logic                running;
    logic                flushing;
    logic [NUM_REGS-1:0] commit_w;
    logic [CYC_W-1:0]    span_w [NUM_REGS];
    logic [CYC_W-1:0]    span_sel;
    logic                any_commit;
    logic [ADD_W-1:0]    add_val;
    logic [ACC_W-1:0]    sum_w;

    assign running  = (st_q.mode == VT_RUN);
    assign flushing = (st_q.mode == VT_FLUSH);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        logic wr_hit, rd_hit, fl_hit;

        always_comb begin
            wr_hit = running & wr_en_i & (wr_idx_i == IDX_W'(g));
            fl_hit = flushing & (st_q.ptr == IDX_W'(g));
            rd_hit = 1'b0;
            for (int p = 0; p < NUM_RD; p++) begin
                rd_hit |= running & rd_en_i[p] & (rd_idx_i[p*IDX_W +: IDX_W] == IDX_W'(g));
            end
        end

        vt_slot #(.CYC_W(CYC_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cycle_i    (cycle_i),
            .wr_hit_i   (wr_hit),
            .rd_hit_i   (rd_hit),
            .flush_hit_i(fl_hit),
            .commit_o   (commit_w[g]),
            .span_o     (span_w[g])
        );
    end

    // One write port and a one-at-a-time flush: at most one slot commits.
    always_comb begin
        span_sel   = '0;
        any_commit = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (commit_w[i]) begin
                span_sel   = span_sel | span_w[i];
                any_commit = 1'b1;
            end
        end
        add_val = any_commit ? (ADD_W'(span_sel) * ADD_W'(DATA_W)) : '0;
    end

    vt_sat_add #(.ACC_W(ACC_W), .ADD_W(ADD_W)) u_acc (
        .acc_i(st_q.total),
        .inc_i(add_val),
        .sum_o(sum_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.total = sum_w;
        unique case (st_q.mode)
            VT_RUN: begin
                if (end_run_i) begin
                    st_d.mode = VT_FLUSH;
                    st_d.ptr  = '0;
                end
            end
            VT_FLUSH: begin
                if (st_q.ptr == LAST_IDX) st_d.mode = VT_DONE;
                else                      st_d.ptr  = st_q.ptr + 1'b1;
            end
            default: st_d.mode = VT_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= VT_RUN;
            st_q.ptr   <= '0;
            st_q.total <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign total_o = st_q.total;
    assign done_o  = (st_q.mode == VT_DONE);

endmodule

// File: rtl/vt_checker.sv
module vt_checker #(
    parameter int ACC_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic             flushing_i,
    input logic [ACC_W-1:0] total_i,
    input logic             done_i
);

    localparam logic [ACC_W-1:0] TOP = {ACC_W{1'b1}};

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (total_i == '0 && !done_i));

    assert_total_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (total_i >= $past(total_i)));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !flushing_i) |=> $stable(total_i));

    assert_done_after_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_i) |-> $past(flushing_i));

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> done_i);

    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> $stable(total_i));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (total_i == TOP) |=> (total_i == TOP));

endmodule

bind reg_vuln_tracker vt_checker #(.ACC_W(ACC_W)) u_vt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .flushing_i(flushing),
    .total_i   (total_o),
    .done_i    (done_o)
);

// File: tb/tb_reg_vuln_tracker.sv
`timescale 1ns/1ps
module tb_reg_vuln_tracker;

    localparam int NR = 16;
    localparam int DW = 32;
    localparam int AW = 40;
    localparam logic [63:0] SAT = (64'd1 << AW) - 64'd1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     cycle_i = '0;
    logic            wr_en_i = 1'b0;
    logic [3:0]      wr_idx_i = '0;
    logic [1:0]      rd_en_i = '0;
    logic [7:0]      rd_idx_i = '0;
    logic            end_run_i = 1'b0;
    logic [AW-1:0]   total_o;
    logic            done_o;

    always #10 clk = ~clk;

    reg_vuln_tracker #(.ACC_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cycle_i(cycle_i), .wr_en_i(wr_en_i),
        .wr_idx_i(wr_idx_i), .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i),
        .end_run_i(end_run_i), .total_o(total_o), .done_o(done_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] cyc = 32'd0;

    // Behavioural reference
    logic [31:0] m_born [NR];
    logic [31:0] m_last [NR];
    bit          m_live [NR];
    bit          m_seen [NR];
    int          m_mode = 0;   // 0 run, 1 flushing, 2 finished
    int          m_ptr  = 0;
    logic [63:0] m_tot  = '0;

    task automatic m_clear();
        for (int i = 0; i < NR; i++) begin
            m_born[i] = '0; m_last[i] = '0; m_live[i] = 0; m_seen[i] = 0;
        end
        m_mode = 0; m_ptr = 0; m_tot = '0;
    endtask

    task automatic m_add(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] d;
        logic [63:0] t;
        d = a - b;
        t = m_tot + 64'(d) * 64'(DW);
        m_tot = (t > SAT) ? SAT : t;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input bit we, input int wi, input bit r0, input int i0,
                        input bit r1, input int i1, input bit er, input string req);
        wr_en_i   = we;
        wr_idx_i  = 4'(wi);
        rd_en_i   = {r1, r0};
        rd_idx_i  = {4'(i1), 4'(i0)};
        end_run_i = er;
        cycle_i   = cyc;
        @(posedge clk);
        if (m_mode == 0) begin
            if (r0 && m_live[i0]) begin m_seen[i0] = 1; m_last[i0] = cyc; end
            if (r1 && m_live[i1]) begin m_seen[i1] = 1; m_last[i1] = cyc; end
            if (we) begin
                if (m_live[wi] && m_seen[wi]) m_add(m_last[wi], m_born[wi]);
                m_live[wi] = 1; m_seen[wi] = 0; m_born[wi] = cyc;
            end
            if (er) begin m_mode = 1; m_ptr = 0; end
        end else if (m_mode == 1) begin
            if (m_live[m_ptr] && m_seen[m_ptr]) m_add(m_last[m_ptr], m_born[m_ptr]);
            m_seen[m_ptr] = 0;
            if (m_ptr == NR - 1) m_mode = 2; else m_ptr++;
        end
        cyc = cyc + 32'd1;
        @(negedge clk);
        check(req, 64'(total_o), m_tot);
        check(req, 64'(done_o), 64'(m_mode == 2));
    endtask

    task automatic idle(input int n, input string req);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en_i = 0; rd_en_i = '0; end_run_i = 0;
        m_clear();
        repeat (2) @(negedge clk);
        check("R1", 64'(total_o), 64'd0);
        check("R1", 64'(done_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 64'(total_o), 64'd0);
        check("R1", 64'(done_o), 64'd0);
    endtask

    bit finished = 0;

    initial begin
        #(64'd200000 * 20);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        @(negedge clk);
        do_reset();

        // R2/R3: write r3 at 100, reads at 105 and 110, overwrite at 120
        cyc = 32'd100;
        step(1, 3, 0, 0, 0, 0, 0, "R2");
        idle(4, "R2");
        step(0, 0, 1, 3, 0, 0, 0, "R3");
        idle(4, "R3");
        step(0, 0, 0, 0, 1, 3, 0, "R3");
        idle(9, "R3");
        step(1, 3, 0, 0, 0, 0, 0, "R2");
        check("R3", 64'(total_o), 64'd320);

        // R4: unread overwrite, and reads of a never-written register
        step(1, 5, 0, 0, 0, 0, 0, "R4");
        idle(3, "R4");
        step(1, 5, 0, 0, 0, 0, 0, "R4");
        step(0, 0, 1, 9, 1, 9, 0, "R4");
        step(1, 9, 0, 0, 0, 0, 0, "R4");
        step(1, 9, 0, 0, 0, 0, 0, "R4");
        check("R4", 64'(total_o), 64'd320);

        // R5: same-cycle read and write of r7, 3 cycles after the write
        step(1, 7, 0, 0, 0, 0, 0, "R5");
        idle(2, "R5");
        step(1, 7, 0, 0, 1, 7, 0, "R5");
        check("R5", 64'(total_o), 64'd416);
        step(1, 7, 0, 0, 0, 0, 0, "R5");
        check("R5", 64'(total_o), 64'd416);

        // R6: both ports in one cycle on r1 and r2
        step(1, 1, 0, 0, 0, 0, 0, "R6");
        step(1, 2, 0, 0, 0, 0, 0, "R6");
        step(0, 0, 1, 1, 1, 2, 0, "R6");
        step(1, 1, 0, 0, 0, 0, 0, "R6");
        check("R6", 64'(total_o), 64'd480);
        step(1, 2, 0, 0, 0, 0, 0, "R6");
        check("R6", 64'(total_o), 64'd512);

        // Mixed traffic over a few registers to force collisions
        for (int k = 0; k < 400; k++) begin
            int s;
            s = int'($urandom_range(0, 15));
            step(s[0], int'($urandom_range(0, 5)), s[1], int'($urandom_range(0, 5)),
                 s[2], int'($urandom_range(0, 5)), 0, "R2");
        end

        // R7: end strobe, then one register per cycle
        step(0, 0, 1, 0, 0, 0, 1, "R7");
        for (int k = 1; k <= NR; k++) begin
            step(0, 0, 0, 0, 0, 0, 0, "R7");
            check("R7", 64'(done_o), 64'(k == NR));
        end
        held = 64'(total_o);
        step(1, 0, 1, 0, 1, 1, 0, "R8");
        step(1, 1, 0, 0, 0, 0, 1, "R8");
        check("R8", 64'(total_o), held);

        // R7 with a hand-computed final value
        do_reset();
        cyc = 32'd1000;
        step(1, 2, 0, 0, 0, 0, 0, "R7");
        step(1, 4, 0, 0, 0, 0, 0, "R7");
        idle(3, "R7");
        step(0, 0, 0, 0, 1, 2, 1, "R7");
        check("R7", 64'(total_o), 64'd0);
        idle(NR, "R7");
        check("R7", 64'(total_o), 64'd160);
        check("R7", 64'(done_o), 64'd1);
        step(1, 2, 1, 4, 0, 0, 0, "R8");
        step(1, 4, 0, 0, 0, 0, 0, "R8");
        check("R8", 64'(total_o), 64'd160);

        // R9: huge spans via cycle jumps until the total clamps
        do_reset();
        cyc = 32'd0;
        step(1, 0, 0, 0, 0, 0, 0, "R9");
        for (int k = 0; k < 10; k++) begin
            cyc = cyc + 32'hFFFF_FFEE;
            step(0, 0, 1, 0, 0, 0, 0, "R9");
            step(1, 0, 0, 0, 0, 0, 0, "R9");
        end
        check("R9", 64'(total_o), SAT);
        step(0, 0, 1, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, 0, 0, "R9");
        check("R9", 64'(total_o), SAT);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule